// File: doc/BRIEF.md
# Floating-Point Status Register and Trap Control

This block keeps the 32-bit floating-point status word of a coprocessor and manages the exception reporting around it. The host loads the whole word with a load command and reads it back with a store command. It starts arithmetic instructions with a third command, and these end when the execution units report completion. When a completion carries a trap request, the block writes the exception class into the low field of the status word. It also raises the trap flag of the status returned to the host. It withholds the result write-back and the host condition-flag update, so a trapped instruction leaves no other trace.

The block also filters a noisy reset request pin. The pin first passes through a synchronizer. A counter then requires an unbroken run of low samples before the reset takes hold. A shorter dip changes nothing. A full-length hold clears the status word and the trap flag and abandons any instruction still waiting for its completion. A separate chip-level asynchronous reset, released synchronously, initializes the block itself.

Top module: `fsr_trap_ctrl`

## Requirements
- R1: A command with `ins_op` = 1 (load) replaces all 32 bits of the status word with `ins_opnd` at the clock edge where `ins_start` is sampled high.
- R2: A command with `ins_op` = 2 (store) drives `wb_valid` high for exactly one cycle after the start edge, with `wb_data` equal to the status word held before that edge.
- R3: A trapping completion sets `trap_q` after its edge. Any later `ins_start` clears `trap_q`, except when a trap is taken at the same edge.
- R4: A trapping completion writes `eu_tt` into status bits [2:0] and leaves bits [31:3] unchanged. The codes are 0 none, 1 underflow, 2 overflow, 3 divide by zero, 4 illegal instruction, 5 invalid operation, 6 inexact.
- R5: A trapping completion produces no `wb_valid` and no `flag_we` pulse.
- R6: A clean completion (`eu_done` high, `eu_exc` low) of an arithmetic instruction (`ins_op` = 0) gives a one-cycle `wb_valid` carrying `eu_result`. In the same cycle `flag_we` pulses with `flag_z` and `flag_n` copied from `eu_z` and `eu_n`.
- R7: The filtered reset takes hold only after `rst_req_n` has been low for 64 consecutive clock edges. A release after 63 edges has no effect on the status word.
- R8: When the filtered reset takes hold, it clears the status word to zero and clears `trap_q`. It also aborts an arithmetic instruction in flight, so that its later completion produces no write-back and no flag update.
- R9: When a trapping completion and a load command share an edge, the load supplies bits [31:3], the trap code supplies bits [2:0], and `trap_q` is set.
- R10: An `eu_done` with no arithmetic instruction in flight is ignored. It produces no write-back, no flag update and no trap, and it leaves the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Chip-level asynchronous reset, active low, released synchronously |
| rst_req_n | input | 1 | Asynchronous reset request, active low, filtered over 64 cycles |
| ins_start | input | 1 | Start-of-instruction strobe |
| ins_op | input | 2 | 0 arithmetic, 1 load status, 2 store status, 3 none |
| ins_opnd | input | 32 | Operand word for the load command |
| eu_done | input | 1 | Execution unit completion strobe |
| eu_exc | input | 1 | Completion carries a trap request |
| eu_tt | input | 3 | Exception class for the trap |
| eu_result | input | 32 | Result word of the completed instruction |
| eu_z | input | 1 | Equal/zero flag from the execution unit |
| eu_n | input | 1 | Greater/negative flag from the execution unit |
| wb_valid | output | 1 | Result write-back strobe |
| wb_data | output | 32 | Result word or stored status word |
| flag_we | output | 1 | Host condition-flag update strobe |
| flag_z | output | 1 | Z flag value for the host |
| flag_n | output | 1 | N flag value for the host |
| trap_q | output | 1 | Trap flag of the status returned to the host |

## Verification
Two functions can meet on one edge: the trap write from a completing instruction, and the start of the next instruction. That next instruction can be a status load, which also writes the status word, or an arithmetic start, which would normally clear the trap flag. The bench provokes both cases by raising `eu_done` with `eu_exc` in the same cycle as `ins_start`. It judges the load case by reading the word back with a store, expecting the operand in bits [31:3] and the trap code in bits [2:0] with `trap_q` high. It judges the arithmetic case by checking that `trap_q` stays high until the filtered reset clears it.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;

  typedef enum logic [1:0] {
    OP_ARITH = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_NONE  = 2'd3
  } fsr_op_e;

  typedef enum logic [2:0] {
    TT_NONE     = 3'd0,
    TT_UNDERFL  = 3'd1,
    TT_OVERFL   = 3'd2,
    TT_DIVZERO  = 3'd3,
    TT_ILLEGAL  = 3'd4,
    TT_INVALID  = 3'd5,
    TT_INEXACT  = 3'd6,
    TT_RESERVED = 3'd7
  } fsr_tt_e;

endpackage

// File: rtl/fsr_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assertion, synchronous release of the chip-level reset.
module fsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/fsr_rst_filter.sv
`timescale 1ns/1ps
// Synchronizes the reset request pin and asserts hold_o only after
// HOLD consecutive low samples; any high sample restarts the run.
module fsr_rst_filter #(
  parameter int HOLD = 64,
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_i,
  output logic hold_o
);

  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(HOLD);

  logic [SYNC-1:0] sync_q;
  logic [SYNC-1:0] sync_d;
  logic            sampled_n;
  logic [CW-1:0]   run_q;
  logic [CW-1:0]   run_d;
  logic            run_en;

  assign sampled_n = sync_q[SYNC-1];

  always_comb begin
    sync_d = {sync_q[SYNC-2:0], req_n_i};
  end

  always_comb begin
    run_en = 1'b1;
    run_d  = run_q;
    if (sampled_n) begin
      run_d = '0;
    end else if (run_q != CNT_MAX) begin
      run_d = run_q + 1'b1;
    end else begin
      run_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      run_q  <= '0;
    end else begin
      sync_q <= sync_d;
      if (run_en) run_q <= run_d;
    end
  end

  assign hold_o = (run_q == CNT_MAX);

endmodule

// File: rtl/fsr_status_reg.sv
`timescale 1ns/1ps
// Status word storage: synchronous clear, full-word load, trap-code
// write into the low field (the trap write wins over a load).
module fsr_status_reg #(
  parameter int W   = 32,
  parameter int TTW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_i,
  input  logic           load_en_i,
  input  logic [W-1:0]   load_val_i,
  input  logic           tt_we_i,
  input  logic [TTW-1:0] tt_val_i,
  output logic [W-1:0]   fsr_o
);

  logic [W-1:0] word_q;
  logic [W-1:0] word_d;
  logic         word_en;

  always_comb begin
    word_en = clr_i | load_en_i | tt_we_i;
    word_d  = word_q;
    if (clr_i) begin
      word_d = '0;
    end else begin
      if (load_en_i) word_d = load_val_i;
      if (tt_we_i)   word_d[TTW-1:0] = tt_val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign fsr_o = word_q;

endmodule

// File: rtl/fsr_trap_ctrl.sv
`timescale 1ns/1ps
module fsr_trap_ctrl #(
  parameter int DATA_W      = 32,
  parameter int TT_W        = 3,
  parameter int HOLD_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              rst_req_n,
  input  logic              ins_start,
  input  logic [1:0]        ins_op,
  input  logic [DATA_W-1:0] ins_opnd,
  input  logic              eu_done,
  input  logic              eu_exc,
  input  logic [TT_W-1:0]   eu_tt,
  input  logic [DATA_W-1:0] eu_result,
  input  logic              eu_z,
  input  logic              eu_n,
  output logic              wb_valid,
  output logic [DATA_W-1:0] wb_data,
  output logic              flag_we,
  output logic              flag_z,
  output logic              flag_n,
  output logic              trap_q
);
  import fsr_pkg::*;

  logic rst_n_s;
  logic filt_hold;

  fsr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n_s)
  );

  fsr_rst_filter #(.HOLD(HOLD_CYCLES), .SYNC(SYNC_STAGES)) u_rst_filter (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .req_n_i (rst_req_n),
    .hold_o  (filt_hold)
  );

  // Command decode
  fsr_op_e op;
  logic    start_ok, is_load, is_store, is_arith;
  logic    done_ok, trap_hit, clean_done;
  logic    busy_q, busy_d;

  assign op       = fsr_op_e'(ins_op);
  assign start_ok = ins_start & ~filt_hold;
  assign is_load  = start_ok & (op == OP_LOAD);
  assign is_store = start_ok & (op == OP_STORE);
  assign is_arith = start_ok & (op == OP_ARITH);

  assign done_ok    = eu_done & busy_q & ~filt_hold;
  assign trap_hit   = done_ok & eu_exc;
  assign clean_done = done_ok & ~eu_exc;

  // Status word
  logic [DATA_W-1:0] fsr_q;

  fsr_status_reg #(.W(DATA_W), .TTW(TT_W)) u_status (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .clr_i      (filt_hold),
    .load_en_i  (is_load),
    .load_val_i (ins_opnd),
    .tt_we_i    (trap_hit),
    .tt_val_i   (eu_tt),
    .fsr_o      (fsr_q)
  );

  // Next-state logic for tracking, trap flag and host outputs
  logic              q_q, q_d;
  logic              wbv_q, wbv_d;
  logic [DATA_W-1:0] wbd_q, wbd_d;
  logic              fwe_q, fwe_d;
  logic              fz_q, fn_q;

  always_comb begin
    if (filt_hold) begin
      busy_d = 1'b0;
      q_d    = 1'b0;
    end else begin
      busy_d = (busy_q & ~done_ok) | is_arith;
      if (trap_hit)      q_d = 1'b1;
      else if (start_ok) q_d = 1'b0;
      else               q_d = q_q;
    end
    wbv_d = clean_done | is_store;
    wbd_d = clean_done ? eu_result : fsr_q;
    fwe_d = clean_done;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q <= 1'b0;
      q_q    <= 1'b0;
      wbv_q  <= 1'b0;
      wbd_q  <= '0;
      fwe_q  <= 1'b0;
      fz_q   <= 1'b0;
      fn_q   <= 1'b0;
    end else begin
      busy_q <= busy_d;
      q_q    <= q_d;
      wbv_q  <= wbv_d;
      fwe_q  <= fwe_d;
      if (wbv_d) wbd_q <= wbd_d;
      if (fwe_d) begin
        fz_q <= eu_z;
        fn_q <= eu_n;
      end
    end
  end

  assign wb_valid = wbv_q;
  assign wb_data  = wbd_q;
  assign flag_we  = fwe_q;
  assign flag_z   = fz_q;
  assign flag_n   = fn_q;
  assign trap_q   = q_q;

endmodule

// File: rtl/fsr_trap_ctrl_chk.sv
`timescale 1ns/1ps
module fsr_trap_ctrl_chk #(
  parameter int DATA_W      = 32,
  parameter int TT_W        = 3,
  parameter int HOLD_CYCLES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold,
  input logic              busy,
  input logic [DATA_W-1:0] fsr,
  input logic              rst_req_n,
  input logic              ins_start,
  input logic [1:0]        ins_op,
  input logic [DATA_W-1:0] ins_opnd,
  input logic              eu_done,
  input logic              eu_exc,
  input logic [TT_W-1:0]   eu_tt,
  input logic [DATA_W-1:0] eu_result,
  input logic              eu_z,
  input logic              eu_n,
  input logic              wb_valid,
  input logic [DATA_W-1:0] wb_data,
  input logic              flag_we,
  input logic              flag_z,
  input logic              flag_n,
  input logic              trap_q
);

  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(HOLD_CYCLES);

  logic [CW-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run <= '0;
    else if (rst_req_n)      low_run <= '0;
    else if (low_run != LIM) low_run <= low_run + 1'b1;
  end

  logic trap_now, clean_now;
  assign trap_now  = eu_done && eu_exc && busy && !hold;
  assign clean_now = eu_done && !eu_exc && busy && !hold;

  p_load_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_start && ins_op == 2'd1 && !hold && !trap_now) |=> fsr == $past(ins_opnd));

  p_store_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_start && ins_op == 2'd2 && !hold && !clean_now) |=> (wb_valid && wb_data == $past(fsr)));

  p_trap_sets_q_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trap_now |=> trap_q);

  p_start_clears_q_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_start && !trap_now) |=> !trap_q);

  p_trap_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_now |=> fsr[TT_W-1:0] == $past(eu_tt));

  p_trap_no_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eu_done && eu_exc) |=> !flag_we);

  p_clean_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clean_now |=> (wb_valid && flag_we && wb_data == $past(eu_result)
                   && flag_z == $past(eu_z) && flag_n == $past(eu_n)));

  p_filter_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(low_run, 2) == LIM);

  p_reset_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (fsr == '0 && !trap_q && !busy && !wb_valid && !flag_we));

  p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (eu_done && !busy) |=> !flag_we);

endmodule

bind fsr_trap_ctrl fsr_trap_ctrl_chk #(
  .DATA_W(DATA_W), .TT_W(TT_W), .HOLD_CYCLES(HOLD_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n_s), .hold(filt_hold), .busy(busy_q), .fsr(fsr_q),
  .rst_req_n(rst_req_n), .ins_start(ins_start), .ins_op(ins_op),
  .ins_opnd(ins_opnd), .eu_done(eu_done), .eu_exc(eu_exc), .eu_tt(eu_tt),
  .eu_result(eu_result), .eu_z(eu_z), .eu_n(eu_n), .wb_valid(wb_valid),
  .wb_data(wb_data), .flag_we(flag_we), .flag_z(flag_z), .flag_n(flag_n),
  .trap_q(trap_q)
);

// File: tb/fsr_trap_ctrl_tb_top.sv
`timescale 1ns/1ps
module fsr_trap_ctrl_tb_top;

  localparam logic [1:0] OP_ARITH = 2'd0;
  localparam logic [1:0] OP_LOAD  = 2'd1;
  localparam logic [1:0] OP_STORE = 2'd2;

  logic        clk = 1'b0;
  logic        arst_n, rst_req_n, ins_start, eu_done, eu_exc, eu_z, eu_n;
  logic [1:0]  ins_op;
  logic [31:0] ins_opnd, eu_result;
  logic [2:0]  eu_tt;
  logic        wb_valid, flag_we, flag_z, flag_n, trap_q;
  logic [31:0] wb_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit all_done = 1'b0;

  always #2.5 clk = ~clk;

  fsr_trap_ctrl dut_i (
    .clk(clk), .arst_n(arst_n), .rst_req_n(rst_req_n),
    .ins_start(ins_start), .ins_op(ins_op), .ins_opnd(ins_opnd),
    .eu_done(eu_done), .eu_exc(eu_exc), .eu_tt(eu_tt),
    .eu_result(eu_result), .eu_z(eu_z), .eu_n(eu_n),
    .wb_valid(wb_valid), .wb_data(wb_data), .flag_we(flag_we),
    .flag_z(flag_z), .flag_n(flag_n), .trap_q(trap_q)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    ins_start = 1'b0; ins_op = 2'd3; ins_opnd = '0;
    eu_done = 1'b0; eu_exc = 1'b0; eu_tt = '0; eu_result = '0; eu_z = 1'b0; eu_n = 1'b0;
  endtask

  task automatic issue(logic [1:0] op, logic [31:0] opnd);
    @(negedge clk);
    ins_start = 1'b1; ins_op = op; ins_opnd = opnd;
    @(negedge clk);
    quiet();
  endtask

  task automatic finish_op(logic exc, logic [2:0] tt, logic [31:0] res, logic z, logic n);
    @(negedge clk);
    eu_done = 1'b1; eu_exc = exc; eu_tt = tt; eu_result = res; eu_z = z; eu_n = n;
    @(negedge clk);
    quiet();
  endtask

  task automatic read_fsr(output logic [31:0] val, output logic vld);
    issue(OP_STORE, '0);
    val = wb_data; vld = wb_valid;
  endtask

  task automatic pulse_req(int edges);
    @(negedge clk);
    rst_req_n = 1'b0;
    repeat (edges) @(negedge clk);
    rst_req_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [31:0] v; logic vld;
    check("R8", "trap_q after reset", {31'd0, trap_q}, 32'd0);
    check("R8", "wb_valid after reset", {31'd0, wb_valid}, 32'd0);
    check("R8", "flag_we after reset", {31'd0, flag_we}, 32'd0);
    read_fsr(v, vld);
    check("R2", "store valid", {31'd0, vld}, 32'd1);
    check("R8", "status after reset", v, 32'd0);
  endtask

  task automatic t_load_store();
    logic [31:0] v; logic vld;
    logic [31:0] pats [3] = '{32'hA5C3_F0F8, 32'h0000_0001, 32'hFFFF_FFFF};
    foreach (pats[i]) begin
      issue(OP_LOAD, pats[i]);
      check("R1", "no write-back on load", {31'd0, wb_valid}, 32'd0);
      read_fsr(v, vld);
      check("R2", "store valid", {31'd0, vld}, 32'd1);
      check("R1", "loaded word", v, pats[i]);
    end
    @(negedge clk);
    check("R2", "wb_valid one cycle", {31'd0, wb_valid}, 32'd0);
  endtask

  task automatic t_clean_ops();
    issue(OP_ARITH, '0);
    finish_op(1'b0, 3'd0, 32'h0000_1234, 1'b1, 1'b0);
    check("R6", "wb_valid", {31'd0, wb_valid}, 32'd1);
    check("R6", "wb_data", wb_data, 32'h0000_1234);
    check("R6", "flag_we/z/n", {29'd0, flag_we, flag_z, flag_n}, 32'b110);
    check("R6", "trap_q clear", {31'd0, trap_q}, 32'd0);
    issue(OP_ARITH, '0);
    finish_op(1'b0, 3'd0, 32'h8765_4321, 1'b0, 1'b1);
    check("R6", "wb_data 2", wb_data, 32'h8765_4321);
    check("R6", "flag_we/z/n 2", {29'd0, flag_we, flag_z, flag_n}, 32'b101);
    @(negedge clk);
    check("R6", "flag_we one cycle", {31'd0, flag_we}, 32'd0);
  endtask

  task automatic t_trap();
    logic [31:0] v; logic vld;
    issue(OP_LOAD, 32'hFFFF_0000);
    issue(OP_ARITH, '0);
    finish_op(1'b1, 3'd3, 32'h1111_1111, 1'b1, 1'b1);
    check("R5", "no wb on trap", {31'd0, wb_valid}, 32'd0);
    check("R5", "no flag_we on trap", {31'd0, flag_we}, 32'd0);
    check("R3", "trap_q set", {31'd0, trap_q}, 32'd1);
    read_fsr(v, vld);
    check("R4", "trap code in [2:0]", v, 32'hFFFF_0003);
    check("R3", "trap_q cleared by next start", {31'd0, trap_q}, 32'd0);
  endtask

  task automatic t_trap_with_load();
    logic [31:0] v; logic vld;
    issue(OP_ARITH, '0);
    @(negedge clk);
    eu_done = 1'b1; eu_exc = 1'b1; eu_tt = 3'd5;
    ins_start = 1'b1; ins_op = OP_LOAD; ins_opnd = 32'h1234_5678;
    @(negedge clk);
    quiet();
    check("R9", "trap_q wins over start", {31'd0, trap_q}, 32'd1);
    check("R9", "no flag_we", {31'd0, flag_we}, 32'd0);
    read_fsr(v, vld);
    check("R9", "merged word", v, 32'h1234_567D);
  endtask

  task automatic t_idle_done();
    logic [31:0] v; logic vld;
    issue(OP_LOAD, 32'h0F0F_0F00);
    finish_op(1'b0, 3'd0, 32'hDEAD_0001, 1'b1, 1'b1);
    check("R10", "no wb when idle", {31'd0, wb_valid}, 32'd0);
    check("R10", "no flag_we when idle", {31'd0, flag_we}, 32'd0);
    finish_op(1'b1, 3'd2, 32'h0, 1'b0, 1'b0);
    check("R10", "no trap when idle", {31'd0, trap_q}, 32'd0);
    read_fsr(v, vld);
    check("R10", "status unchanged", v, 32'h0F0F_0F00);
  endtask

  task automatic t_short_low();
    logic [31:0] v; logic vld;
    issue(OP_LOAD, 32'hCAFE_0010);
    pulse_req(63);
    read_fsr(v, vld);
    check("R7", "63-cycle low ignored", v, 32'hCAFE_0010);
  endtask

  task automatic t_full_low();
    logic [31:0] v; logic vld;
    issue(OP_LOAD, 32'hDEAD_BEE0);
    issue(OP_ARITH, '0);
    @(negedge clk);
    eu_done = 1'b1; eu_exc = 1'b1; eu_tt = 3'd1;
    ins_start = 1'b1; ins_op = OP_ARITH;
    @(negedge clk);
    quiet();
    check("R3", "trap_q held over arith start", {31'd0, trap_q}, 32'd1);
    pulse_req(64);
    check("R8", "trap_q cleared by reset", {31'd0, trap_q}, 32'd0);
    finish_op(1'b0, 3'd0, 32'h5555_AAAA, 1'b1, 1'b0);
    check("R8", "aborted op no wb", {31'd0, wb_valid}, 32'd0);
    check("R8", "aborted op no flag_we", {31'd0, flag_we}, 32'd0);
    read_fsr(v, vld);
    check("R7", "64-cycle low resets status", v, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!all_done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    quiet();
    arst_n = 1'b0; rst_req_n = 1'b1;
    repeat (4) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_load_store();
    t_clean_ops();
    t_trap();
    t_trap_with_load();
    t_idle_done();
    t_short_low();
    t_full_low();
    all_done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule